// File: doc/BRIEF.md
# Time-Division Multiplexed Sample Word Serialiser

This block carries fixed-width sample words from several voice channels over one serial line. A frame strobe marks the start of each sampling period. On that strobe the block copies every channel word into a holding bank. It then sends one frame of slots, one bit for each bit-clock enable. The first slot holds a fixed synchronisation word. Channel 1 follows, then channel 2, and so on up to channel N. The far-end demultiplexer can find the sync word and lock its channel numbering to the transmitter.

The integration picks the number of channels so that all slots fit into one sampling period. The sampling period divided by the time to send one word, rounded down, gives the number of slots, and one of them goes to sync. For example, at 8 kHz framing with 12-bit words, a bit enable every 1 µs leaves room for ten slots in each 125 µs frame. When all slots have been sent, the line idles at 0 until the next strobe. A strobe that arrives before the frame is complete raises a one-cycle overrun pulse and restarts the frame.

The controller is a four-state machine:
- `TX_IDLE`: the state after reset.
- `TX_SYNC`: the sync slot is going out.
- `TX_CHAN`: the channel slots are going out.
- `TX_DONE`: the frame is complete and the line is idle.

Its transitions are:
- Any state goes to `TX_SYNC` on a frame strobe. This is the *restart* transition.
- `TX_SYNC` goes to `TX_CHAN` after the last sync bit. This is the *sync-complete* transition.
- `TX_CHAN` stays in `TX_CHAN` after the last bit of a channel slot that is not the final one. This is the *next-channel* transition.
- `TX_CHAN` goes to `TX_DONE` after the last bit of channel N. This is the *frame-complete* transition.

Top module: `tdm_frame_tx`

## Requirements
- R1: After reset, `ser_bit`, `bit_valid`, `frame_start` and `overrun` are all 0. They stay 0 until the first frame strobe, whatever `bit_en` does.
- R2: A frame is (NUM_CH+1)·WORD_W bits long. The sync slot comes first, then channel 0 (`ch_words[WORD_W-1:0]`), then each higher channel index in ascending order. Each consumed `bit_en` sends exactly one bit.
- R3: Every slot is sent most significant bit first. The sync slot carries the parameter `SYNC_PAT`.
- R4: `bit_valid` is 1 in the cycle after a rising clock edge that consumed a `bit_en` during a frame, and 0 in every other cycle.
- R5: `frame_start` is 1 only together with the first bit of the sync slot.
- R6: Channel words are sampled on the strobe edge. Changing `ch_words` later has no effect on the frame being sent.
- R7: A strobe that arrives while the sync or channel slots are still being sent gives `overrun` = 1 for exactly one cycle. The frame then restarts from the sync slot, using the newly captured words.
- R8: After the final channel bit, `ser_bit` and `bit_valid` stay 0 until the next strobe, and `bit_en` is ignored.
- R9: When a strobe and `bit_en` occur in the same cycle, the strobe takes precedence and no bit is sent in that cycle.
- R10: Each bit appears on `ser_bit` in the cycle right after the edge that consumed its `bit_en`. It is a registered output with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | One-cycle marker of a sampling instant |
| bit_en | input | 1 | Bit-clock enable; one bit is sent for each enable |
| ch_words | input | NUM_CH·WORD_W | Channel sample words; channel k occupies bits k·WORD_W upward |
| ser_bit | output | 1 | Serial line data |
| bit_valid | output | 1 | A bit is on `ser_bit` in this cycle |
| frame_start | output | 1 | Marks the first sync bit of a frame |
| overrun | output | 1 | One-cycle pulse when a frame was cut short by a strobe |

## Verification
Some internal faults show up at the ports immediately. A bit or slot counter that is off by one moves a slot boundary, so the first wrong `ser_bit` appears within one word time of the fault. A state machine that leaves `TX_DONE` without a strobe shows up as a stray `bit_valid` at the next `bit_en`. Other faults only show up later. A holding bank that follows its inputs instead of the strobe is invisible until a channel slot is sent after the inputs have changed, so the bench changes the words in the middle of a frame. A wrong overrun decision shows up one cycle after the strobe, on `overrun`, and as a `frame_start` that is late or missing.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SYNC = 2'd1,
        TX_CHAN = 2'd2,
        TX_DONE = 2'd3
    } tx_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdm_hold_bank.sv
module tdm_hold_bank #(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W  = tdm_pkg::idx_width(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture,
    input  logic [NUM_CH*WORD_W-1:0] words_in,
    input  logic [CH_W-1:0]          sel,
    output logic [WORD_W-1:0]        word_out
);

    logic [WORD_W-1:0] bank [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (capture) begin
                bank[g] <= words_in[g*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        word_out = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel == CH_W'(i)) begin
                word_out = bank[i];
            end
        end
    end

    AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(bank[0]))  // R6
        else $error("bank changed without capture");

endmodule

// File: rtl/tdm_slot_fsm.sv
module tdm_slot_fsm
    import tdm_pkg::*;
#(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W  = tdm_pkg::idx_width(NUM_CH),
    localparam int unsigned BIT_W = tdm_pkg::idx_width(WORD_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_strobe,
    input  logic            bit_en,
    output tx_state_e       state_o,
    output logic            emit_o,
    output logic            first_bit_o,
    output logic            load_sync_o,
    output logic            load_word_o,
    output logic            shift_o,
    output logic [CH_W-1:0] word_sel_o,
    output logic            overrun_set_o
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);

    tx_state_e         state_q, state_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [CH_W-1:0]   ch_q, ch_d;
    logic              busy;
    logic              emit;
    logic              last_bit;
    logic              last_ch;

    assign busy     = (state_q == TX_SYNC) || (state_q == TX_CHAN);
    assign emit     = bit_en && !frame_strobe && busy;
    assign last_bit = (bit_q == LAST_BIT);
    assign last_ch  = (ch_q == LAST_CH);

    // next-state and slot counters
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        ch_d    = ch_q;
        if (frame_strobe) begin
            state_d = TX_SYNC;
            bit_d   = '0;
            ch_d    = '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                end
                TX_SYNC: begin
                    if (emit) begin
                        if (last_bit) begin
                            state_d = TX_CHAN;
                            bit_d   = '0;
                            ch_d    = '0;
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end
                end
                TX_CHAN: begin
                    if (emit) begin
                        if (last_bit) begin
                            bit_d = '0;
                            if (last_ch) begin
                                state_d = TX_DONE;
                            end else begin
                                ch_d = ch_q + 1'b1;
                            end
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end
                end
                TX_DONE: begin
                end
                default: begin
                    state_d = TX_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            bit_q   <= '0;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            ch_q    <= ch_d;
        end
    end

    // control outputs
    always_comb begin
        state_o       = state_q;
        emit_o        = emit;
        first_bit_o   = (state_q == TX_SYNC) && (bit_q == '0);
        load_sync_o   = frame_strobe;
        load_word_o   = emit && last_bit && !((state_q == TX_CHAN) && last_ch);
        shift_o       = emit && !load_word_o;
        overrun_set_o = frame_strobe && busy;
        if (state_q == TX_SYNC) begin
            word_sel_o = '0;
        end else if (last_ch) begin
            word_sel_o = ch_q;
        end else begin
            word_sel_o = ch_q + 1'b1;
        end
    end

    AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ch_q <= LAST_CH)  // R2
        else $error("channel index out of range");

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DONE && !frame_strobe) |=> (state_q == TX_DONE))  // R8
        else $error("left done state without strobe");

    AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> (state_q == TX_SYNC && bit_q == '0))  // R7
        else $error("strobe did not restart frame");

endmodule

// File: rtl/tdm_piso.sv
module tdm_piso #(
    parameter int unsigned          WORD_W   = 12,
    parameter logic [WORD_W-1:0]    SYNC_PAT = 12'hB47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_sync,
    input  logic              load_word,
    input  logic              shift,
    input  logic [WORD_W-1:0] word_in,
    output logic              msb_o
);

    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load_sync) begin
            shreg <= SYNC_PAT;
        end else if (load_word) begin
            shreg <= word_in;
        end else if (shift) begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
        end
    end

    assign msb_o = shreg[WORD_W-1];

    AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        load_sync |-> !(load_word || shift))  // R9
        else $error("strobe collided with shift");

    AST_SYNC_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        load_sync |=> (shreg == SYNC_PAT))  // R3
        else $error("sync pattern not loaded");

endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx
    import tdm_pkg::*;
#(
    parameter int unsigned       WORD_W   = 12,
    parameter int unsigned       NUM_CH   = 4,
    parameter logic [WORD_W-1:0] SYNC_PAT = 12'hB47
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_strobe,
    input  logic                     bit_en,
    input  logic [NUM_CH*WORD_W-1:0] ch_words,
    output logic                     ser_bit,
    output logic                     bit_valid,
    output logic                     frame_start,
    output logic                     overrun
);

    localparam int unsigned CH_W = tdm_pkg::idx_width(NUM_CH);

    tx_state_e         state;
    logic              emit;
    logic              first_bit;
    logic              load_sync;
    logic              load_word;
    logic              shift;
    logic [CH_W-1:0]   word_sel;
    logic              overrun_set;
    logic [WORD_W-1:0] next_word;
    logic              line_msb;

    tdm_hold_bank #(
        .WORD_W (WORD_W),
        .NUM_CH (NUM_CH)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (frame_strobe),
        .words_in (ch_words),
        .sel      (word_sel),
        .word_out (next_word)
    );

    tdm_slot_fsm #(
        .WORD_W (WORD_W),
        .NUM_CH (NUM_CH)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_strobe  (frame_strobe),
        .bit_en        (bit_en),
        .state_o       (state),
        .emit_o        (emit),
        .first_bit_o   (first_bit),
        .load_sync_o   (load_sync),
        .load_word_o   (load_word),
        .shift_o       (shift),
        .word_sel_o    (word_sel),
        .overrun_set_o (overrun_set)
    );

    tdm_piso #(
        .WORD_W   (WORD_W),
        .SYNC_PAT (SYNC_PAT)
    ) u_piso (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_sync (load_sync),
        .load_word (load_word),
        .shift     (shift),
        .word_in   (next_word),
        .msb_o     (line_msb)
    );

    // registered line outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_bit     <= 1'b0;
            bit_valid   <= 1'b0;
            frame_start <= 1'b0;
            overrun     <= 1'b0;
        end else begin
            ser_bit     <= emit && line_msb;
            bit_valid   <= emit;
            frame_start <= emit && first_bit;
            overrun     <= overrun_set;
        end
    end

    AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(bit_en))  // R4
        else $error("valid without bit enable");

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> !ser_bit)  // R8
        else $error("line not idle low");

    AST_START_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> bit_valid)  // R5
        else $error("frame start without valid bit");

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(frame_strobe))  // R7
        else $error("overrun without strobe");

    AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> !bit_valid)  // R9
        else $error("bit sent on strobe cycle");

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE || state == TX_DONE) && !frame_strobe |=> !bit_valid)  // R1
        else $error("bit sent outside frame");

endmodule

// File: tb/tdm_frame_tx_bench.sv
module tdm_frame_tx_bench;

    localparam int unsigned       WORD_W   = 12;
    localparam int unsigned       NUM_CH   = 4;
    localparam logic [WORD_W-1:0] SYNC_PAT = 12'hB47;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     frame_strobe = 1'b0;
    logic                     bit_en = 1'b0;
    logic [NUM_CH*WORD_W-1:0] ch_words = '0;
    logic                     ser_bit, bit_valid, frame_start, overrun;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int en_div = 1;
    int en_cnt = 0;
    string phase = "R1";

    // reference model state
    bit exp_q[$];
    bit fs_pending = 0;
    bit m_bit = 0, m_valid = 0, m_fs = 0, m_ovr = 0;
    bit model_live = 0;

    int        sync_cnt = 0;
    logic [WORD_W-1:0] sync_acc = '0;

    tdm_frame_tx #(
        .WORD_W   (WORD_W),
        .NUM_CH   (NUM_CH),
        .SYNC_PAT (SYNC_PAT)
    ) u_tdm_frame_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .bit_en       (bit_en),
        .ch_words     (ch_words),
        .ser_bit      (ser_bit),
        .bit_valid    (bit_valid),
        .frame_start  (frame_start),
        .overrun      (overrun)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s act=%b exp=%b t=%0t", req, phase, what, act, exp, $time);
        end
    endtask

    // behavioural model, one step per rising edge
    always @(posedge clk) begin
        cyc++;
        model_live = 1;
        if (!rst_n) begin
            exp_q.delete();
            fs_pending = 0;
            m_bit = 0; m_valid = 0; m_fs = 0; m_ovr = 0;
        end else begin
            m_ovr = frame_strobe && (exp_q.size() > 0);
            if (frame_strobe) begin
                exp_q.delete();
                for (int b = WORD_W - 1; b >= 0; b--) exp_q.push_back(SYNC_PAT[b]);
                for (int c = 0; c < NUM_CH; c++)
                    for (int b = WORD_W - 1; b >= 0; b--)
                        exp_q.push_back(ch_words[c*WORD_W + b]);
                fs_pending = 1;
                m_bit = 0; m_valid = 0; m_fs = 0;
            end else if (bit_en && exp_q.size() > 0) begin
                m_bit = exp_q.pop_front();
                m_valid = 1;
                m_fs = fs_pending;
                fs_pending = 0;
            end else begin
                m_bit = 0; m_valid = 0; m_fs = 0;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (model_live) begin
            check("R10", "ser_bit", ser_bit, m_bit);
            check("R4", "bit_valid", bit_valid, m_valid);
            check("R5", "frame_start", frame_start, m_fs);
            check("R7", "overrun", overrun, m_ovr);
        end
        if (bit_valid) begin
            if (frame_start) begin
                sync_cnt = 1;
                sync_acc = {{(WORD_W-1){1'b0}}, ser_bit};
            end else if (sync_cnt > 0) begin
                sync_acc = {sync_acc[WORD_W-2:0], ser_bit};
                sync_cnt++;
            end
            if (sync_cnt == WORD_W) begin
                checks++;
                if (sync_acc !== SYNC_PAT) begin
                    errors++;
                    $display("FAIL R3 sync word act=%h exp=%h", sync_acc, SYNC_PAT);
                end
                sync_cnt = 0;
            end
        end
    end

    // bit enable generator
    always @(negedge clk) begin
        en_cnt = (en_cnt + 1) % en_div;
        bit_en <= (en_cnt == 0);
    end

    task automatic strobe_pulse();
        @(negedge clk) frame_strobe = 1'b1;
        @(negedge clk) frame_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 100000) begin
                errors++;
                $display("FAIL R2 watchdog act=%0d exp<=100000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        phase = "R1";
        ch_words = {12'h0F0, 12'hA5C, 12'h3E1, 12'h81F};
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R1", "reset ser_bit", ser_bit, 1'b0);
        check("R1", "reset bit_valid", bit_valid, 1'b0);
        check("R1", "reset overrun", overrun, 1'b0);
        idle(20);

        phase = "R2";
        en_div = 1;
        strobe_pulse();
        idle(75);
        phase = "R8";
        idle(30);

        phase = "R6";
        en_div = 3;
        strobe_pulse();
        idle(10);
        ch_words = {12'hFFF, 12'h000, 12'h555, 12'hAAA};
        idle(200);

        phase = "R7";
        en_div = 1;
        strobe_pulse();
        idle(30);
        ch_words = {12'h123, 12'h456, 12'h789, 12'hCDE};
        strobe_pulse();
        idle(80);

        phase = "R9";
        en_div = 1;
        strobe_pulse();
        idle(WORD_W*(NUM_CH+1) - 2);
        strobe_pulse();
        idle(90);

        phase = "R3";
        en_div = 2;
        ch_words = {12'h800, 12'h001, 12'h7FE, 12'hC03};
        strobe_pulse();
        idle(140);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule